// File: doc/BRIEF.md
# Hierarchical State Region Manager

This block controls a single composite state of a hierarchical state machine. Inside the region sits a chain of leaf states. Each leaf has its own activity bit. At any time no leaf or exactly one leaf is active. Event-triggered arcs join neighbouring leaves. An arc can move activity from its source leaf to its destination leaf only while the region is enabled.

The region is switched on by an entry strobe. On entry it loads a clean leaf vector, so nothing left over from earlier activity survives. The leaf it starts in depends on an entry-mode select. In default mode it starts in a fixed leaf. In history mode it resumes the leaf that was active when the region was last left. An exit strobe acts as an interrupt: it drops the enable, clears every leaf and records the leaf vector for a later history entry.

Events reach every arc through a broadcast vector. A parameter selects how arcs use it. Either all arcs share event bit 0, which gives the clock-setting chain where one button press moves activity from minutes to tens to hours. Or arc k listens to its own bit, k modulo the event width.

Top module: `region_mgr`

## Requirements
- R1: On synchronous reset the leaf vector is all zero, the region is inactive and the history record is empty.
- R2: An entry in default mode (`hist_mode_i`=0) on an inactive region makes it active with only leaf `DEF_LEAF` set, one cycle after the strobe.
- R3: An entry in history mode (`hist_mode_i`=1) resumes the leaf that was active at the most recent exit from an active region.
- R4: A history-mode entry with no exit recorded since reset falls back to leaf `DEF_LEAF`.
- R5: While the region is active, if leaf k (k < N_LEAF-1) is set and its arc event is high, leaf k+1 becomes the only set leaf next cycle. The arc event is `evt_i[0]` when SHARED_EVT=1 and `evt_i[k % N_EVT]` otherwise. The last leaf has no outgoing arc and holds its state.
- R6: Events have no effect while the region is inactive; the leaf vector stays zero.
- R7: An exit clears all leaves and the active flag on the next cycle. If the region was active, the exit also records its leaf vector as the history.
- R8: When entry and exit strobes coincide, the exit wins.
- R9: An entry strobe while the region is already active is ignored.
- R10: While active, exactly one leaf is set; while inactive, none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high global reset |
| entry_i | input | 1 | Incoming arc crossed (entry strobe) |
| hist_mode_i | input | 1 | Entry mode: 0 default leaf, 1 resume history |
| exit_i | input | 1 | Region exit strobe |
| evt_i | input | N_EVT | Broadcast event vector |
| leaf_o | output | N_LEAF | One-hot active leaf vector |
| active_o | output | 1 | Region enabled flag |

## Verification
The bench builds the block with N_LEAF=4, N_EVT=4, SHARED_EVT=0 and DEF_LEAF=1. With a default leaf that is not leaf 0, a default entry can be told apart from a reset value. Giving each arc its own event bit shows that an arc responds only to its own trigger and not to its neighbours' events. Four leaves give history entries enough distinct leaves to resume, including the last leaf, which has no outgoing arc.

// File: rtl/region_mgr.sv
module region_mgr #(
  parameter int N_LEAF     = 3,
  parameter int N_EVT      = 1,
  parameter int DEF_LEAF   = 0,
  parameter bit SHARED_EVT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_i,
  input  logic              hist_mode_i,
  input  logic              exit_i,
  input  logic [N_EVT-1:0]  evt_i,
  output logic [N_LEAF-1:0] leaf_o,
  output logic              active_o
);

  localparam logic [N_LEAF-1:0] DEF_VEC = N_LEAF'(1) << DEF_LEAF;

  logic [N_LEAF-1:0] leaf, hist, fire, stepped;
  logic              en, hist_ok;

  genvar k;
  generate
    for (k = 0; k < N_LEAF; k++) begin : g_arc
      localparam logic [N_EVT-1:0] MASK = SHARED_EVT ? N_EVT'(1) : (N_EVT'(1) << (k % N_EVT));
      if (k < N_LEAF - 1) begin : g_out
        assign fire[k] = en & leaf[k] & (|(evt_i & MASK));
      end else begin : g_last
        assign fire[k] = 1'b0;
      end
      if (k == 0) begin : g_first
        assign stepped[k] = leaf[k] & ~fire[k];
      end else begin : g_mid
        assign stepped[k] = (leaf[k] & ~fire[k]) | fire[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      leaf    <= '0;
      hist    <= '0;
      hist_ok <= 1'b0;
      en      <= 1'b0;
    end else if (exit_i) begin
      if (en) begin
        hist    <= leaf;
        hist_ok <= 1'b1;
      end
      leaf <= '0;
      en   <= 1'b0;
    end else if (entry_i && !en) begin
      en   <= 1'b1;
      leaf <= (hist_mode_i && hist_ok) ? hist : DEF_VEC;
    end else if (en) begin
      leaf <= stepped;
    end
  end

  assign leaf_o   = leaf;
  assign active_o = en;

  p_onehot_active_r10: assert property (@(posedge clk) disable iff (rst)
    active_o |-> $countones(leaf_o) == 1);
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> leaf_o == '0);
  p_exit_clears_r7: assert property (@(posedge clk) disable iff (rst)
    exit_i |=> (!active_o && leaf_o == '0));
  p_default_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (entry_i && !exit_i && !active_o && !hist_mode_i) |=> leaf_o == DEF_VEC);
  p_history_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (entry_i && !exit_i && !active_o && hist_mode_i && hist_ok) |=> leaf_o == $past(hist));
  p_no_event_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (active_o && !exit_i && evt_i == '0) |=> $stable(leaf_o));

endmodule

// File: tb/region_mgr_tb_top.sv
module region_mgr_tb_top;
  localparam int NL = 4, NE = 4, DEF = 1;

  logic clk = 0, rst = 1, entry_i = 0, hist_mode_i = 0, exit_i = 0;
  logic [NE-1:0] evt_i = '0;
  logic [NL-1:0] leaf_o;
  logic active_o;

  int checks = 0, errors = 0;
  int m_idx = -1, m_hidx = -1;
  bit m_act = 0, m_hv = 0;
  bit done = 0;

  always #10 clk = ~clk;

  region_mgr #(.N_LEAF(NL), .N_EVT(NE), .DEF_LEAF(DEF), .SHARED_EVT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .entry_i(entry_i), .hist_mode_i(hist_mode_i),
    .exit_i(exit_i), .evt_i(evt_i), .leaf_o(leaf_o), .active_o(active_o));

  function automatic logic [NL-1:0] vec(int idx);
    return (idx < 0) ? '0 : (NL'(1) << idx);
  endfunction

  task automatic check(string tag);
    checks++;
    if (leaf_o !== vec(m_idx) || active_o !== m_act) begin
      errors++;
      $display("FAIL %s leaf=%b act=%b expected leaf=%b act=%b", tag, leaf_o, active_o, vec(m_idx), m_act);
    end
  endtask

  task automatic model_step();
    if (exit_i) begin
      if (m_act) begin m_hidx = m_idx; m_hv = 1; end
      m_idx = -1; m_act = 0;
    end else if (entry_i && !m_act) begin
      m_act = 1;
      m_idx = (hist_mode_i && m_hv) ? m_hidx : DEF;
    end else if (m_act) begin
      if (m_idx < NL - 1 && evt_i[m_idx % NE]) m_idx = m_idx + 1;
    end
  endtask

  task automatic cyc(bit en, bit hm, bit ex, logic [NE-1:0] ev, string tag);
    entry_i = en; hist_mode_i = hm; exit_i = ex; evt_i = ev;
    model_step();
    @(posedge clk); @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1; entry_i = 0; exit_i = 0; evt_i = '0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    m_idx = -1; m_act = 0; m_hidx = -1; m_hv = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset state");
    cyc(0, 0, 0, 4'b1111, "R6 events while inactive");
    cyc(1, 1, 0, 4'b0000, "R4 history with empty record");
    cyc(0, 0, 0, 4'b0001, "R5 foreign event no move");
    cyc(0, 0, 0, 4'b0010, "R5 arc leaf1 to leaf2");
    cyc(1, 0, 0, 4'b0000, "R9 entry while active ignored");
    cyc(0, 0, 0, 4'b0100, "R5 arc leaf2 to leaf3");
    cyc(0, 0, 0, 4'b1111, "R5 last leaf holds");
    cyc(0, 0, 1, 4'b0000, "R7 exit clears");
    cyc(1, 0, 1, 4'b0000, "R8 exit beats entry");
    cyc(1, 0, 0, 4'b0000, "R2 default entry");
    cyc(0, 0, 1, 4'b0000, "R7 exit records leaf1");
    cyc(1, 1, 0, 4'b0000, "R3 history resumes");
    cyc(0, 0, 1, 4'b0000, "R7 exit again");
    do_reset();
    check("R1 second reset");
    cyc(1, 1, 0, 4'b0000, "R4 history cleared by reset");
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      bit en = ($urandom % 5) == 0;
      bit ex = ($urandom % 9) == 0;
      bit hm = $urandom % 2;
      logic [NE-1:0] ev = (($urandom % 3) == 0) ? NE'($urandom) : '0;
      cyc(en, hm, ex, ev, "R10 random sequence");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule